// File: doc/BRIEF.md
# Timer Interrupt Flag Logic

This block keeps the two status flags of an 8-bit timer, one for overflow and one for compare match, and turns them into interrupt request lines. The counter and comparator sit outside and hand in single-cycle event pulses. A mode input picks which event sets the overflow flag. In single-slope operation that event is the counter wrapping around. In dual-slope PWM operation it is the counter turning around at the bottom of its range.

Software clears a flag by writing a one to its bit position. The interrupt controller clears a flag by pulsing that flag's vector acknowledge. A request line is high while its flag is set, its own enable is set and the global enable is set. The request follows the enables in the same cycle.

Each flag is a two-state machine. FLAG_CLEAR moves to FLAG_SET on a set event. FLAG_SET moves back to FLAG_CLEAR on a clear that has no set event in the same cycle. Every other case holds the current state.

Top module: `tif_flags`

## Requirements
- R1: While reset is asserted and after its release, `flag_rd` is 2'b00 and both request lines are low.
- R2: With `dual_slope_mode` = 0, a `wrap_evt` pulse sets the overflow flag (`flag_rd[0]`) at the next clock edge, and `bottom_turn_evt` does not set it.
- R3: With `dual_slope_mode` = 1, a `bottom_turn_evt` pulse sets the overflow flag at the next clock edge, and `wrap_evt` does not set it.
- R4: A `match_evt` pulse sets the compare flag (`flag_rd[1]`) at the next clock edge in either mode.
- R5: A cycle with `flag_wr_en` high clears each flag whose bit in `flag_wr_data` is 1 (bit 0 overflow, bit 1 compare) and leaves each flag whose bit is 0 unchanged.
- R6: `ovf_ack` clears the overflow flag and `cmp_ack` clears the compare flag at the next clock edge.
- R7: When a set event and a clear (write-one or acknowledge) reach the same flag in one cycle, the flag ends up set.
- R8: `ovf_irq` equals `global_ie & ovf_ie & flag_rd[0]` and `cmp_irq` equals `global_ie & cmp_ie & flag_rd[1]`, with no added clock latency.
- R9: A flag with no set event and no clear in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrap_evt | input | 1 | Counter wrapped around its top value |
| match_evt | input | 1 | Counter equals the compare value |
| bottom_turn_evt | input | 1 | Counter reversed direction at zero |
| dual_slope_mode | input | 1 | 1 selects dual-slope PWM operation |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| flag_wr_en | input | 1 | Bus write strobe to the flag bits |
| flag_wr_data | input | 2 | Write data; a one clears that flag |
| ovf_ack | input | 1 | Overflow vector acknowledge pulse |
| cmp_ack | input | 1 | Compare vector acknowledge pulse |
| flag_rd | output | 2 | Flag read-back: bit 0 overflow, bit 1 compare |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
Every set, clear and acknowledge shows up on `flag_rd` one clock edge after the cycle in which it was driven. The request lines depend only on the stored flags and the enables, so they are valid in the same cycle. The bench drives each stimulus on a falling edge. It then reads `flag_rd` and the requests on the next falling edge, when exactly one rising edge has passed. To show the zero latency of the requests, the bench changes only the enables and samples the request lines one nanosecond later, with no clock edge in between.

// File: rtl/tif_pkg.sv
package tif_pkg;
    localparam int NUM_FLAGS = 2;
    localparam int OVF_BIT   = 0;
    localparam int CMP_BIT   = 1;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/tif_set_select.sv
module tif_set_select (
    input  logic clk,
    input  logic rst_n,
    input  logic dual_slope_mode,
    input  logic wrap_evt,
    input  logic bottom_turn_evt,
    output logic ovf_set
);
    always_comb begin
        ovf_set = dual_slope_mode ? bottom_turn_evt : wrap_evt;
    end

    // R2: in single-slope mode a bottom turn alone never sets the flag
    a_r2_turn_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_slope_mode && !wrap_evt) |-> !ovf_set);

    // R3: in dual-slope mode a wrap alone never sets the flag
    a_r3_wrap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_slope_mode && !bottom_turn_evt) |-> !ovf_set);
endmodule

// File: rtl/tif_flag_cell.sv
module tif_flag_cell
    import tif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pending_o
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_i) state_d = FLAG_SET;
            FLAG_SET:   if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        pending_o = (state_q == FLAG_SET);
    end

    // R7: a set event always leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pending_o);

    // R5 and R6: a clear without a set empties the flag
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pending_o);

    // R9: no event, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(pending_o));
endmodule

// File: rtl/tif_irq_gate.sv
module tif_irq_gate
    import tif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 global_ie,
    input  logic [NUM_FLAGS-1:0] flag_ie,
    input  logic [NUM_FLAGS-1:0] flag_q,
    output logic [NUM_FLAGS-1:0] irq
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_gate
        always_comb begin
            irq[g] = global_ie & flag_ie[g] & flag_q[g];
        end

        // R8: a request never appears without its stored flag
        a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> flag_q[g]);
    end
endmodule

// File: rtl/tif_flags.sv
module tif_flags
    import tif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap_evt,
    input  logic       match_evt,
    input  logic       bottom_turn_evt,
    input  logic       dual_slope_mode,
    input  logic       ovf_ie,
    input  logic       cmp_ie,
    input  logic       global_ie,
    input  logic       flag_wr_en,
    input  logic [1:0] flag_wr_data,
    input  logic       ovf_ack,
    input  logic       cmp_ack,
    output logic [1:0] flag_rd,
    output logic       ovf_irq,
    output logic       cmp_irq
);
    logic                 ovf_set;
    logic [NUM_FLAGS-1:0] set_vec, ack_vec, clr_vec, ie_vec, pend_vec, irq_vec;

    tif_set_select u_sel (
        .clk             (clk),
        .rst_n           (rst_n),
        .dual_slope_mode (dual_slope_mode),
        .wrap_evt        (wrap_evt),
        .bottom_turn_evt (bottom_turn_evt),
        .ovf_set         (ovf_set)
    );

    always_comb begin
        set_vec          = '0;
        ack_vec          = '0;
        ie_vec           = '0;
        set_vec[OVF_BIT] = ovf_set;
        set_vec[CMP_BIT] = match_evt;
        ack_vec[OVF_BIT] = ovf_ack;
        ack_vec[CMP_BIT] = cmp_ack;
        ie_vec[OVF_BIT]  = ovf_ie;
        ie_vec[CMP_BIT]  = cmp_ie;
        clr_vec          = ack_vec | (flag_wr_en ? flag_wr_data : '0);
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        tif_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[f]),
            .clr_i     (clr_vec[f]),
            .pending_o (pend_vec[f])
        );
    end

    tif_irq_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .global_ie (global_ie),
        .flag_ie   (ie_vec),
        .flag_q    (pend_vec),
        .irq       (irq_vec)
    );

    always_comb begin
        flag_rd = pend_vec;
        ovf_irq = irq_vec[OVF_BIT];
        cmp_irq = irq_vec[CMP_BIT];
    end

    // R1: reset leaves both flags empty
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flag_rd == 2'b00));

    // R4: a compare match is visible one edge later
    a_r4_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> flag_rd[CMP_BIT]);

    // R6: an acknowledge with no set clears the overflow flag
    a_r6_ovf_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack && !ovf_set) |=> !flag_rd[OVF_BIT]);
endmodule

// File: tb/tb_tif_flags.sv
module tb_tif_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wrap_evt = 0, match_evt = 0, bottom_turn_evt = 0, dual_slope_mode = 0;
    logic       ovf_ie = 0, cmp_ie = 0, global_ie = 0, flag_wr_en = 0;
    logic [1:0] flag_wr_data = 0;
    logic       ovf_ack = 0, cmp_ack = 0;
    logic [1:0] flag_rd;
    logic       ovf_irq, cmp_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tif_flags dut (
        .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt), .match_evt(match_evt),
        .bottom_turn_evt(bottom_turn_evt), .dual_slope_mode(dual_slope_mode),
        .ovf_ie(ovf_ie), .cmp_ie(cmp_ie), .global_ie(global_ie),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
        .flag_rd(flag_rd), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
    );

    // fields: wrap match turn mode | wr_en wd[1:0] | oack cack | oie cie gie | exp_flags[1:0] | oirq cirq
    localparam int NV = 17;
    localparam logic [15:0] VECS [NV] = '{
        16'b1000_0_00_00_000_01_00,
        16'b0000_0_00_00_100_01_00,
        16'b0000_0_00_00_101_01_10,
        16'b0000_1_01_00_101_00_00,
        16'b0010_0_00_00_101_00_00,
        16'b1001_0_00_00_101_00_00,
        16'b0011_0_00_00_101_01_10,
        16'b0101_0_00_00_111_11_11,
        16'b0001_1_00_00_111_11_11,
        16'b0001_1_10_00_111_01_10,
        16'b0001_0_00_10_111_00_00,
        16'b0100_0_00_01_111_10_01,
        16'b1000_1_01_00_111_11_11,
        16'b0000_0_00_01_111_01_10,
        16'b0000_0_00_00_011_01_00,
        16'b0000_0_00_00_110_01_00,
        16'b0000_1_11_00_111_00_00
    };

    function automatic string req_of(int i);
        case (i)
            0:        return "R2";
            1, 2:     return "R8";
            3, 8, 9:  return "R5";
            4:        return "R2";
            5, 6:     return "R3";
            7:        return "R4";
            10, 13:   return "R6";
            11, 12:   return "R7";
            14, 15:   return "R8";
            default:  return "R5";
        endcase
    endfunction

    task automatic check3(string req, logic [1:0] ef, logic eo, logic ec);
        checks++;
        if (flag_rd !== ef || ovf_irq !== eo || ec !== cmp_irq) begin
            fails++;
            $display("FAIL %s: flags=%b ovf_irq=%b cmp_irq=%b expected flags=%b ovf_irq=%b cmp_irq=%b",
                     req, flag_rd, ovf_irq, cmp_irq, ef, eo, ec);
        end
    endtask

    initial begin : watchdog
        #100000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check3("R1", 2'b00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1", 2'b00, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            {wrap_evt, match_evt, bottom_turn_evt, dual_slope_mode} = VECS[i][15:12];
            flag_wr_en   = VECS[i][11];
            flag_wr_data = VECS[i][10:9];
            {ovf_ack, cmp_ack}          = VECS[i][8:7];
            {ovf_ie, cmp_ie, global_ie} = VECS[i][6:4];
            @(negedge clk);
            check3(req_of(i), VECS[i][3:2], VECS[i][1], VECS[i][0]);
        end

        // R9: idle cycles hold a set pair of flags
        {wrap_evt, match_evt, bottom_turn_evt, dual_slope_mode} = 4'b1100;
        flag_wr_en = 0; {ovf_ack, cmp_ack} = 2'b00;
        {ovf_ie, cmp_ie, global_ie} = 3'b000;
        @(negedge clk);
        {wrap_evt, match_evt} = 2'b00;
        repeat (3) @(negedge clk);
        check3("R9", 2'b11, 1'b0, 1'b0);

        // R8: requests follow the enables with no clock edge
        {ovf_ie, cmp_ie, global_ie} = 3'b111;
        #1 check3("R8", 2'b11, 1'b1, 1'b1);
        global_ie = 1'b0;
        #1 check3("R8", 2'b11, 1'b0, 1'b0);
        {ovf_ie, cmp_ie, global_ie} = 3'b011;
        #1 check3("R8", 2'b11, 1'b0, 1'b1);

        // R1: reset in mid-run empties set flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check3("R1", 2'b00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1", 2'b00, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule